// File: doc/BRIEF.md
# Event Readout Frame Builder

This block turns one trigger into one self-describing readout frame of 32-bit words for a 64-channel digitizer board. The board's channels form four groups of sixteen. At the start of a frame the block latches the trigger's metadata and two 64-bit channel masks. One mask selects the channels whose processed results are reported. The other selects the channels whose raw waveform samples are copied out.

The frame is built in a fixed order. First come seven words: a constant marker, the trigger identity, a summary word and the two masks. Next comes one processed result word per hit channel, pulled from an upstream result stream. After that come the raw sample blocks, which are read from a sample memory that has one cycle of read latency. The frame closes with a constant trailer word.

Every word leaves through a valid/ready port. While `out_ready` is low the current word and `out_valid` are held, and nothing is dropped. An internal queue of a few entries with credit accounting lets the memory reads run back to back without overrunning the queue. The trigger port and the result stream are also valid/ready. A trigger is taken only when the block is idle and its output queue is empty. A result is taken only while the result section is being built.

Top module: `evt_frame_packer`

## Requirements
- R1: Word 0 of every frame is 0xFFAA0000. Word 1 holds the trigger tag in bits 7..0, zeros in bits 23..8 and the event number in bits 31..24.
- R2: Word 2 holds the trigger time in bits 4..0, a zero in bit 5, the trigger source code in bits 7..6, the hit count in bits 15..8, the samples-per-channel value in bits 23..16 and the raw channel count in bits 31..24.
- R3: Words 3 and 4 hold hit-mask bits 31..0 and 63..32. Words 5 and 6 hold raw-mask bits 31..0 and 63..32. Mask bit n is channel n, and bit 16g+k is channel k+1 of group g+1.
- R4: The hit count equals the number of set bits in the hit mask, and the raw channel count equals the number of set bits in the raw mask.
- R5: Starting at word 7, exactly one word per hit channel is emitted, packed as {flags[1:0], time[11:0], amplitude[17:0]} from successive result-stream transfers. `res_ready` is high only during this section.
- R6: For each raw-marked channel, in ascending channel order, the block emits L sample words read at address {channel[5:0], sample[5:0]} with the sample index running 0..L-1. The read data is returned one cycle after `smp_rd_en`.
- R7: The last word is 0xFF550000 with `out_last` high, at offset 7 + hit count + raw count × L. No other word has `out_last` high.
- R8: An all-zero hit mask gives an empty result section. An all-zero raw mask or L = 0 gives an empty raw section. In both cases the count fields still report the mask popcounts.
- R9: A requested samples-per-channel value above 64 is clamped to L = 64. The clamped value is the one reported in word 2 and the one used in the raw section.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold. Every word is delivered exactly once.
- R11: `trig_ready` is high only when no frame is in progress and the output queue is empty. Trigger inputs presented during a frame do not alter it.
- R12: With `out_ready` held high, the words of the raw section leave on consecutive cycles.
- R13: An active-low reset, including one asserted mid-frame, returns the block to idle. After reset `out_valid`, `res_ready` and `smp_rd_en` are low and `trig_ready` is high, and the next frame starts with word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger metadata and masks valid |
| trig_ready | output | 1 | Block idle and output drained; trigger taken on valid & ready |
| trig_tag | input | 8 | Trigger tag |
| trig_evnum | input | 8 | Event number |
| trig_time | input | 5 | Trigger time, 0..23 |
| trig_src | input | 2 | Trigger source code |
| trig_raw_len | input | 8 | Requested samples per raw channel (clamped to 64) |
| trig_hit_mask | input | 64 | Channels with processed results |
| trig_raw_mask | input | 64 | Channels with raw sample capture |
| res_valid | input | 1 | Result word available |
| res_ready | output | 1 | Result taken on valid & ready |
| res_amp | input | 18 | Result amplitude |
| res_time | input | 12 | Result time |
| res_flags | input | 2 | Result flags |
| smp_rd_en | output | 1 | Sample memory read strobe |
| smp_rd_addr | output | 12 | Sample memory address {channel, sample} |
| smp_rd_data | input | 32 | Sample memory data, one cycle after the strobe |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Output word |
| out_last | output | 1 | Marks the trailer word |

## Verification
The hardest state to reach is a stall in `out_ready` that lands while a memory read is already in flight and the output queue is nearly full. It matters most when the stall comes just as the walk steps to the next raw channel or hands over to the trailer. The stimulus gets there with raw-heavy frames under pseudo-random and alternating ready patterns, which cause back-pressure at every phase of the raw walk. A long frame with ready held high checks that the credit scheme adds no bubbles. Frames with an empty hit section, an empty raw section, a zero or oversized sample count, and a trigger held high with changing contents throughout a frame cover the section-skipping and ignore cases.

// File: rtl/evt_pack_pkg.sv
package evt_pack_pkg;

  localparam logic [31:0] FRAME_OPEN  = 32'hFFAA0000;
  localparam logic [31:0] FRAME_CLOSE = 32'hFF550000;

  localparam int AMP_W = 18;
  localparam int TIM_W = 12;
  localparam int FLG_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_RES,
    ST_RAW,
    ST_FTR
  } pk_state_e;

endpackage

// File: rtl/evt_popcnt.sv
module evt_popcnt #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end

endmodule

// File: rtl/evt_lowest_bit.sv
module evt_lowest_bit #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any = |vec;

endmodule

// File: rtl/evt_out_fifo.sv
module evt_out_fifo #(
  parameter int DW    = 33,
  parameter int DEPTH = 4,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_push,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [LW-1:0] level,
  output logic          pop
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign out_valid = (level != '0);
  assign out_data  = mem[rp];
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (in_push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (in_push) wp <= adv(wp);
      if (pop)     rp <= adv(rp);
      case ({in_push, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  // R10: the queue never takes a word it has no room for
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    in_push |-> (level < LW'(DEPTH)) || pop);

  // R10: a stalled word is held unchanged
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/evt_frame_packer.sv
module evt_frame_packer
  import evt_pack_pkg::*;
#(
  parameter int NCH        = 64,
  parameter int MAX_LEN    = 64,
  parameter int FIFO_DEPTH = 4,
  localparam int CH_W      = $clog2(NCH),
  localparam int SMP_W     = $clog2(MAX_LEN),
  localparam int ADDR_W    = CH_W + SMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic [7:0]        trig_tag,
  input  logic [7:0]        trig_evnum,
  input  logic [4:0]        trig_time,
  input  logic [1:0]        trig_src,
  input  logic [7:0]        trig_raw_len,
  input  logic [NCH-1:0]    trig_hit_mask,
  input  logic [NCH-1:0]    trig_raw_mask,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [AMP_W-1:0]  res_amp,
  input  logic [TIM_W-1:0]  res_time,
  input  logic [FLG_W-1:0]  res_flags,
  output logic              smp_rd_en,
  output logic [ADDR_W-1:0] smp_rd_addr,
  input  logic [31:0]       smp_rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic              out_last
);

  localparam int CNT_W   = $clog2(NCH + 1);
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int MW      = NCH / 32;
  localparam int HDR_LEN = 3 + 2 * MW;
  localparam int HI_W    = $clog2(HDR_LEN);
  localparam int FC_W    = $clog2(FIFO_DEPTH + 1);

  pk_state_e        state;
  logic [HI_W-1:0]  hdr_idx;
  logic [CNT_W-1:0] res_left;
  logic [NCH-1:0]   raw_work;
  logic [SMP_W-1:0] smp_idx;
  logic             inflight;

  logic [7:0]       tag_q, evn_q;
  logic [4:0]       time_q;
  logic [1:0]       src_q;
  logic [NCH-1:0]   hit_q, raw_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] dsp_cnt_q, raw_cnt_q;

  logic [CNT_W-1:0] hit_cnt_d, raw_cnt_d;
  logic [LEN_W-1:0] len_d;
  logic [CH_W-1:0]  cur_ch;
  logic             raw_any;
  logic             raw_next_empty;
  logic             chan_done;

  logic [FC_W-1:0]  fifo_lvl;
  logic             fifo_pop;
  logic             space;
  logic             accept;
  logic             dpush;
  logic [31:0]      dword;
  logic             dlast;
  logic             fpush;
  logic [32:0]      fdata;
  logic [32:0]      fout;
  logic [31:0]      hdr_word;

  evt_popcnt #(.W(NCH), .CW(CNT_W)) u_cnt_hit (.vec(trig_hit_mask), .cnt(hit_cnt_d));
  evt_popcnt #(.W(NCH), .CW(CNT_W)) u_cnt_raw (.vec(trig_raw_mask), .cnt(raw_cnt_d));
  evt_lowest_bit #(.W(NCH), .IW(CH_W)) u_pick (.vec(raw_work), .idx(cur_ch), .any(raw_any));

  assign len_d = (trig_raw_len > 8'(MAX_LEN)) ? LEN_W'(MAX_LEN) : LEN_W'(trig_raw_len);

  // header word selection
  always_comb begin
    hdr_word = '0;
    if (hdr_idx == HI_W'(0)) begin
      hdr_word = FRAME_OPEN;
    end else if (hdr_idx == HI_W'(1)) begin
      hdr_word = {evn_q, 16'h0000, tag_q};
    end else if (hdr_idx == HI_W'(2)) begin
      hdr_word = {8'(raw_cnt_q), 8'(len_q), 8'(dsp_cnt_q), src_q, 1'b0, time_q};
    end else begin
      for (int m = 0; m < MW; m++) begin
        if (hdr_idx == HI_W'(3 + m))      hdr_word = hit_q[32*m +: 32];
        if (hdr_idx == HI_W'(3 + MW + m)) hdr_word = raw_q[32*m +: 32];
      end
    end
  end

  // credit: queued words plus the read in flight must leave room
  assign space = (FC_W'(fifo_lvl) + FC_W'(inflight)) < (FC_W'(FIFO_DEPTH) + FC_W'(fifo_pop));

  assign trig_ready  = (state == ST_IDLE) && (fifo_lvl == '0);
  assign accept      = trig_valid && trig_ready;
  assign res_ready   = (state == ST_RES) && space;
  assign smp_rd_en   = (state == ST_RAW) && space;
  assign smp_rd_addr = {cur_ch, smp_idx};

  assign chan_done      = (LEN_W'(smp_idx) + LEN_W'(1)) == len_q;
  assign raw_next_empty = (raw_work & ~(NCH'(1) << cur_ch)) == '0;

  always_comb begin
    dpush = 1'b0;
    dword = '0;
    dlast = 1'b0;
    case (state)
      ST_HDR: begin
        dpush = space;
        dword = hdr_word;
      end
      ST_RES: begin
        dpush = res_valid && space;
        dword = {res_flags, res_time, res_amp};
      end
      ST_FTR: begin
        dpush = space && !inflight;
        dword = FRAME_CLOSE;
        dlast = 1'b1;
      end
      default: ;
    endcase
  end

  assign fpush = dpush || inflight;
  assign fdata = inflight ? {1'b0, smp_rd_data} : {dlast, dword};

  evt_out_fifo #(.DW(33), .DEPTH(FIFO_DEPTH), .LW(FC_W)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_push  (fpush),
    .in_data  (fdata),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (fout),
    .level    (fifo_lvl),
    .pop      (fifo_pop)
  );

  assign out_data = fout[31:0];
  assign out_last = fout[32];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q     <= '0;
      evn_q     <= '0;
      time_q    <= '0;
      src_q     <= '0;
      hit_q     <= '0;
      raw_q     <= '0;
      len_q     <= '0;
      dsp_cnt_q <= '0;
      raw_cnt_q <= '0;
    end else if (accept) begin
      tag_q     <= trig_tag;
      evn_q     <= trig_evnum;
      time_q    <= trig_time;
      src_q     <= trig_src;
      hit_q     <= trig_hit_mask;
      raw_q     <= trig_raw_mask;
      len_q     <= len_d;
      dsp_cnt_q <= hit_cnt_d;
      raw_cnt_q <= raw_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      hdr_idx  <= '0;
      res_left <= '0;
      raw_work <= '0;
      smp_idx  <= '0;
      inflight <= 1'b0;
    end else begin
      inflight <= smp_rd_en;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_HDR;
            hdr_idx  <= '0;
            res_left <= hit_cnt_d;
            raw_work <= (len_d == '0) ? '0 : trig_raw_mask;
            smp_idx  <= '0;
          end
        end
        ST_HDR: begin
          if (space) begin
            hdr_idx <= hdr_idx + HI_W'(1);
            if (hdr_idx == HI_W'(HDR_LEN - 1)) begin
              if (res_left != '0)  state <= ST_RES;
              else if (raw_any)    state <= ST_RAW;
              else                 state <= ST_FTR;
            end
          end
        end
        ST_RES: begin
          if (res_valid && space) begin
            res_left <= res_left - CNT_W'(1);
            if (res_left == CNT_W'(1)) state <= raw_any ? ST_RAW : ST_FTR;
          end
        end
        ST_RAW: begin
          if (space) begin
            if (chan_done) begin
              smp_idx          <= '0;
              raw_work[cur_ch] <= 1'b0;
              if (raw_next_empty) state <= ST_FTR;
            end else begin
              smp_idx <= smp_idx + SMP_W'(1);
            end
          end
        end
        ST_FTR: begin
          if (space && !inflight) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: an accepted trigger closes the trigger port for the next cycle
  a_r11_one_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_ready) |=> !trig_ready);

  // R7: a word flagged last is always the trailer
  a_r7_last_is_close: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_data == FRAME_CLOSE));

  // R6: sample index stays inside the clamped block length
  a_r6_addr_in_len: assert property (@(posedge clk) disable iff (!rst_n)
    smp_rd_en |-> (LEN_W'(smp_rd_addr[SMP_W-1:0]) < len_q));

  // R5: no result is taken beyond the hit count
  a_r5_res_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |-> (res_left != '0));

endmodule

// File: tb/tb_evt_frame_packer.sv
`timescale 1ns/1ps
module tb_evt_frame_packer;

  typedef struct packed {
    logic [7:0]  tag;
    logic [7:0]  evn;
    logic [4:0]  tm;
    logic [1:0]  src;
    logic [7:0]  len;
    logic [63:0] hit;
    logic [63:0] raw;
    logic [1:0]  rdy_mode;
    logic        res_gap;
    logic        hold_trig;
  } tv_t;

  localparam int NV = 7;
  localparam tv_t VECS [NV] = '{
    '{8'h11, 8'h01, 5'd5,  2'd0, 8'd4,   64'h0000_0000_8000_0003, 64'h0001_0000_0000_0010, 2'd0, 1'b0, 1'b0},
    '{8'h22, 8'h02, 5'd23, 2'd1, 8'd3,   64'h0,                   64'hF000_0000_0000_0001, 2'd1, 1'b0, 1'b1},
    '{8'h33, 8'h03, 5'd0,  2'd2, 8'd5,   64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                   2'd2, 1'b1, 1'b0},
    '{8'h44, 8'h04, 5'd12, 2'd0, 8'd64,  64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 2'd0, 1'b0, 1'b0},
    '{8'h55, 8'h05, 5'd7,  2'd1, 8'd200, 64'h0,                   64'h0000_0000_0000_0100, 2'd2, 1'b0, 1'b0},
    '{8'h66, 8'h06, 5'd1,  2'd2, 8'd0,   64'h0000_0000_0000_0010, 64'h0000_0000_0000_00FF, 2'd0, 1'b0, 1'b0},
    '{8'h77, 8'hFF, 5'd23, 2'd0, 8'd9,   64'h0,                   64'h0,                   2'd1, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_valid = 1'b0;
  logic        trig_ready;
  logic [7:0]  trig_tag = '0, trig_evnum = '0, trig_raw_len = '0;
  logic [4:0]  trig_time = '0;
  logic [1:0]  trig_src = '0;
  logic [63:0] trig_hit_mask = '0, trig_raw_mask = '0;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [17:0] res_amp;
  logic [11:0] res_time;
  logic [1:0]  res_flags;
  logic        smp_rd_en;
  logic [11:0] smp_rd_addr;
  logic [31:0] smp_rd_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_last;

  evt_frame_packer dut (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_ready(trig_ready),
    .trig_tag(trig_tag), .trig_evnum(trig_evnum), .trig_time(trig_time),
    .trig_src(trig_src), .trig_raw_len(trig_raw_len),
    .trig_hit_mask(trig_hit_mask), .trig_raw_mask(trig_raw_mask),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_amp(res_amp), .res_time(res_time), .res_flags(res_flags),
    .smp_rd_en(smp_rd_en), .smp_rd_addr(smp_rd_addr), .smp_rd_data(smp_rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  always #2 clk = ~clk;

  int   checks = 0;
  int   failures = 0;
  int   cyc = 0;
  int   res_k = 0;
  tv_t  cur = '0;
  int   L = 0, dsp = 0, rn = 0, base = 0, total = 0;
  int   widx = 0;
  bit   collecting = 0;
  bit   done = 0;
  bit   busy_seen = 0;
  bit   prev_stall = 0;
  logic [31:0] prev_data = '0;
  int   last_raw_cyc = 0;
  logic [7:0] lf = 8'hA1;

  function automatic int popc(input logic [63:0] m);
    int n = 0;
    for (int i = 0; i < 64; i++) n += int'(m[i]);
    return n;
  endfunction

  function automatic int nth_set(input logic [63:0] m, input int n);
    int seen = 0;
    for (int i = 0; i < 64; i++) begin
      if (m[i]) begin
        if (seen == n) return i;
        seen++;
      end
    end
    return -1;
  endfunction

  function automatic logic [31:0] samp(input int ch, input int s);
    return {8'h5A, 2'b00, 6'(ch), 2'b00, 6'(s), 8'h3C};
  endfunction

  function automatic logic [31:0] rword(input int k);
    return {2'(k), 12'(k + 100), 18'(k * 7 + 3)};
  endfunction

  assign res_amp   = 18'(res_k * 7 + 3);
  assign res_time  = 12'(res_k + 100);
  assign res_flags = 2'(res_k);

  // sample memory model, one cycle latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (smp_rd_en) smp_rd_data <= samp(int'(smp_rd_addr[11:6]), int'(smp_rd_addr[5:0]));
    if (res_valid && res_ready) res_k <= res_k + 1;
  end

  function automatic logic [31:0] exp_word(input int i);
    int j;
    case (i)
      0: return 32'hFFAA0000;
      1: return {cur.evn, 16'h0000, cur.tag};
      2: return {8'(rn), 8'(L), 8'(dsp), cur.src, 1'b0, cur.tm};
      3: return cur.hit[31:0];
      4: return cur.hit[63:32];
      5: return cur.raw[31:0];
      6: return cur.raw[63:32];
      default: ;
    endcase
    if (i < 7 + dsp) return rword(base + i - 7);
    j = i - 7 - dsp;
    if (j < rn * L) return samp(nth_set(cur.raw, j / L), j % L);
    return 32'hFF550000;
  endfunction

  function automatic string sect_tag(input int i);
    if (i < 2) return "R1";
    if (i == 2) return (cur.len > 8'd64) ? "R9" : "R2";
    if (i < 7) return "R3";
    if (i < 7 + dsp) return "R5";
    if (i < 7 + dsp + rn * L) return "R6";
    return (dsp == 0 || rn * L == 0) ? "R8" : "R7";
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // input drive and output observation, away from the rising edge
  always @(negedge clk) begin
    logic [31:0] e;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    case (cur.rdy_mode)
      2'd0:    out_ready = 1'b1;
      2'd1:    out_ready = cyc[0];
      default: out_ready = lf[0];
    endcase
    res_valid = cur.res_gap ? cyc[1] : 1'b1;

    if (prev_stall && rst_n)
      check(out_valid && out_data == prev_data, "R10", "stalled word held",
            {31'b0, out_valid, out_data}, {32'h1, prev_data});
    prev_stall = rst_n && out_valid && !out_ready;
    prev_data  = out_data;

    if (collecting && !done) begin
      if (widx > 0 && trig_ready) busy_seen = 1;
      if (out_valid && out_ready) begin
        e = exp_word(widx);
        check(out_data == e, sect_tag(widx), $sformatf("word %0d", widx), 64'(out_data), 64'(e));
        if (widx >= 7 + dsp && widx < 7 + dsp + rn * L) begin
          if (cur.rdy_mode == 2'd0 && widx > 7 + dsp)
            check(cyc == last_raw_cyc + 1, "R12", "raw words back to back",
                  64'(cyc), 64'(last_raw_cyc + 1));
          last_raw_cyc = cyc;
        end
        if (out_last || widx == total - 1) begin
          check(out_last && widx == total - 1, (dsp == 0 || rn * L == 0) ? "R8" : "R7",
                "trailer position", 64'(widx), 64'(total - 1));
          done = 1;
        end
        widx++;
      end
    end
  end

  task automatic run_frame(input int vi);
    cur   = VECS[vi];
    L     = (cur.len > 8'd64) ? 64 : int'(cur.len);
    dsp   = popc(cur.hit);
    rn    = popc(cur.raw);
    total = 8 + dsp + rn * L;
    @(negedge clk);
    check(trig_ready == 1'b1, "R11", "idle before frame", 64'(trig_ready), 64'h1);
    base = res_k;
    widx = 0; done = 0; busy_seen = 0;
    trig_tag = cur.tag; trig_evnum = cur.evn; trig_time = cur.tm; trig_src = cur.src;
    trig_raw_len = cur.len; trig_hit_mask = cur.hit; trig_raw_mask = cur.raw;
    trig_valid = 1'b1;
    collecting = 1;
    @(negedge clk);
    if (cur.hold_trig) begin
      trig_tag = ~cur.tag; trig_evnum = ~cur.evn; trig_raw_len = 8'd1;
      trig_hit_mask = ~cur.hit; trig_raw_mask = ~cur.raw;
    end else begin
      trig_valid = 1'b0;
    end
    while (!done && cyc < 90000) @(negedge clk);
    trig_valid = 1'b0;
    collecting = 0;
    // R4 word 2 counts are checked through exp_word; R11 busy flag below
    check(!busy_seen, "R11", "trig_ready low during frame", 64'(busy_seen), 64'h0);
    check(done, "R7", "frame completed", 64'(done), 64'h1);
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual cycle %0d expected below 100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check(!out_valid, "R13", "out_valid after reset", 64'(out_valid), 64'h0);
    check(trig_ready, "R13", "trig_ready after reset", 64'(trig_ready), 64'h1);
    check(!res_ready && !smp_rd_en, "R13", "read strobes after reset",
          64'({res_ready, smp_rd_en}), 64'h0);

    for (int vi = 0; vi < NV; vi++) run_frame(vi);

    // R13: reset in the middle of a long raw frame
    cur = VECS[3];
    @(negedge clk);
    trig_tag = cur.tag; trig_evnum = cur.evn; trig_time = cur.tm; trig_src = cur.src;
    trig_raw_len = cur.len; trig_hit_mask = cur.hit; trig_raw_mask = cur.raw;
    trig_valid = 1'b1;
    @(negedge clk);
    trig_valid = 1'b0;
    repeat (25) @(posedge clk);
    #1 rst_n = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && trig_ready, "R13", "idle after mid-frame reset",
          64'({out_valid, trig_ready}), 64'h1);
    check(!smp_rd_en && !res_ready, "R13", "no reads after mid-frame reset",
          64'({smp_rd_en, res_ready}), 64'h0);
    repeat (2) @(negedge clk);
    run_frame(0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule